// File: doc/BRIEF.md
# Hierarchical Interrupt Controller with Auto-Disable

This block gathers event lines from a transmit section and a receive section into a single active-high interrupt request. Each event line has a sticky status bit and its own enable bit. Each section also has a block-level enable bit that can only suppress its sources and can never enable them. A free-running timebase raises a periodic "one-second" source. The period is a parameter given in clock cycles, so a short value can be used in simulation.

Software uses a small synchronous register bus. A read returns data combinationally in the same cycle, and any clear-on-read side effect takes place at the clock edge that ends the read. An operating-mode register holds general framer control fields and the block's own controls, which are exported on `mode_o`. One control selects auto-disable: each source's enable bit is dropped once that source fires, so a flood from one cause cannot keep the processor trapped in its handler. Another control is a self-clearing soft reset.

Top module: `irq_hier_ctrl`

## Requirements
- R1: After reset, the mode register reads 0x2B, the block-enable register reads 0x00, every source-enable register reads 0x00, and `irq_o` is low.
- R2: A rising edge on any event input sets its status bit whatever the enables are. The bit stays set until it is cleared by a read or a reset.
- R3: `irq_o` is the OR of three terms: the one-second term, tx-block-enable AND the OR over tx sources of (status AND enable), and the same for rx. Block enable bit 0 is the one-second enable, bit 1 is tx and bit 2 is rx.
- R4: With a block-enable bit at 0, no source of that section drives `irq_o`. With it at 1, a source whose own enable is 0 still does not drive `irq_o`.
- R5: Reading a source status register clears it to zero at the end of the read. An event rising in the same cycle as the read leaves its bit set.
- R6: A tick every SEC_CYCLES clock cycles sets status bit 0 of the block status register. Reading the block status register clears that bit. Block enable bit 0 gates the tick onto `irq_o`, so an enabled tick raises a request once per period.
- R7: When mode bit 3 is 1, a rising event on a source whose enable is set clears that enable at the same edge. The request from that source stays asserted until its status is cleared. When mode bit 3 is 0, enables change only by bus writes.
- R8: Writing the mode register with bit 4 set returns all registers and the timebase to their reset values at that edge. Bit 4 always reads back 0.
- R9: The register map is 0x0 mode, 0x4 block enable, 0x5 block status (bit 0 one-second status, bit 1 tx pending, bit 2 rx pending; a section is pending when any of its sources has status AND enable set), 0x8 tx enable, 0x9 tx status, 0xA rx enable and 0xB rx status. Unmapped addresses read 0, and block status is read-only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe (clear-on-read side effects) |
| bus_addr_i | input | 4 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, combinational from address |
| tx_evt_i | input | TX_N | Transmit-section event lines, rising-edge sensitive |
| rx_evt_i | input | RX_N | Receive-section event lines, rising-edge sensitive |
| mode_o | output | 8 | Current operating-mode register contents |
| irq_o | output | 1 | Active-high interrupt request |

## Verification
The assertions assume three things about the inputs. A bus write and a bus read never occur in the same cycle. Event lines are steady between clock edges. SEC_CYCLES is at least 2, so a tick never lasts two cycles. The auto-disable check also assumes no write to an enable register coincides with a firing source, because a write takes priority. The bench drives every input at the falling edge, issues one bus operation at a time, and holds each event pulse for one full cycle. It times its enable writes so that they never land on the edge of an event.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned AW = 4;
  localparam int unsigned DW = 8;

  localparam logic [AW-1:0] A_MODE   = 4'h0;
  localparam logic [AW-1:0] A_BLK_EN = 4'h4;
  localparam logic [AW-1:0] A_BLK_ST = 4'h5;
  localparam logic [AW-1:0] A_TX_EN  = 4'h8;
  localparam logic [AW-1:0] A_TX_ST  = 4'h9;
  localparam logic [AW-1:0] A_RX_EN  = 4'hA;
  localparam logic [AW-1:0] A_RX_ST  = 4'hB;

  localparam logic [DW-1:0] MODE_RST = 8'h2B;
  localparam int unsigned M_AUTO = 3;
  localparam int unsigned M_SRST = 4;

  localparam int unsigned B_SEC = 0;
  localparam int unsigned B_TX  = 1;
  localparam int unsigned B_RX  = 2;
endpackage

// File: rtl/irqc_src_bank.sv
module irqc_src_bank #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         srst_i,
  input  logic [N-1:0] evt_i,
  input  logic         auto_i,
  input  logic         en_we_i,
  input  logic [N-1:0] en_wdata_i,
  input  logic         st_rd_i,
  output logic [N-1:0] en_o,
  output logic [N-1:0] st_o,
  output logic [N-1:0] act_o
);
  logic [N-1:0] prev_q, st_q, en_q, hit_q;
  logic [N-1:0] rise, en_d, hit_d, st_d;

  assign rise = evt_i & ~prev_q;

  always_comb begin
    st_d = (st_rd_i ? '0 : st_q) | rise;  // new event beats the read
    if (en_we_i)     en_d = en_wdata_i;
    else if (auto_i) en_d = en_q & ~rise;
    else             en_d = en_q;
    // hit keeps the request alive after auto-disable drops the enable
    hit_d = (st_rd_i ? '0 : hit_q) | ((auto_i && !en_we_i) ? (rise & en_q) : '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= evt_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= '0;
      en_q  <= '0;
      hit_q <= '0;
    end else if (srst_i) begin
      st_q  <= '0;
      en_q  <= '0;
      hit_q <= '0;
    end else begin
      st_q  <= st_d;
      en_q  <= en_d;
      hit_q <= hit_d;
    end
  end

  assign en_o  = en_q;
  assign st_o  = st_q;
  assign act_o = st_q & (en_q | hit_q);

  for (genvar i = 0; i < N; i++) begin : g_chk
    // R2
    st_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q[i] && !st_rd_i && !srst_i) |=> st_q[i]);
    // R5
    evt_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rise[i] && !srst_i) |=> st_q[i]);
    // R7
    auto_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (auto_i && rise[i] && en_q[i] && !en_we_i && !srst_i) |=> !en_q[i]);
    // R7
    en_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!auto_i && !en_we_i && !srst_i) |=> $stable(en_q[i]));
    // R7
    hit_st_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit_q[i] |-> st_q[i]);
  end
endmodule

// File: rtl/irqc_sec_timer.sv
module irqc_sec_timer #(
  parameter int unsigned SEC_CYCLES = 100_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic srst_i,
  output logic tick_o
);
  localparam int unsigned CW = (SEC_CYCLES > 2) ? $clog2(SEC_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(SEC_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (srst_i)      cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                  cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);

  // R6
  tick_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/irqc_reg_if.sv
module irqc_reg_if
  import irqc_pkg::*;
#(
  parameter int unsigned TX_N = 4,
  parameter int unsigned RX_N = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic            rd_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   rdata_o,
  output logic [DW-1:0]   mode_o,
  output logic            srst_o,
  output logic            tx_blk_o,
  output logic            rx_blk_o,
  input  logic            sec_en_i,
  input  logic            sec_st_i,
  input  logic            tx_pend_i,
  input  logic            rx_pend_i,
  input  logic [TX_N-1:0] tx_en_i,
  input  logic [TX_N-1:0] tx_st_i,
  input  logic [RX_N-1:0] rx_en_i,
  input  logic [RX_N-1:0] rx_st_i,
  output logic            sec_en_we_o,
  output logic            tx_en_we_o,
  output logic            rx_en_we_o,
  output logic            sec_rd_o,
  output logic            tx_rd_o,
  output logic            rx_rd_o
);
  logic [DW-1:0] mode_q;
  logic          tx_blk_q, rx_blk_q;
  logic          mode_we, blk_we;

  assign mode_we     = wr_i && (addr_i == A_MODE);
  assign blk_we      = wr_i && (addr_i == A_BLK_EN);
  assign srst_o      = mode_we && wdata_i[M_SRST];
  assign sec_en_we_o = blk_we;
  assign tx_en_we_o  = wr_i && (addr_i == A_TX_EN);
  assign rx_en_we_o  = wr_i && (addr_i == A_RX_EN);
  assign sec_rd_o    = rd_i && (addr_i == A_BLK_ST);
  assign tx_rd_o     = rd_i && (addr_i == A_TX_ST);
  assign rx_rd_o     = rd_i && (addr_i == A_RX_ST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= MODE_RST;
      tx_blk_q <= 1'b0;
      rx_blk_q <= 1'b0;
    end else if (srst_o) begin
      mode_q   <= MODE_RST;
      tx_blk_q <= 1'b0;
      rx_blk_q <= 1'b0;
    end else begin
      if (mode_we) mode_q <= wdata_i;
      if (blk_we) begin
        tx_blk_q <= wdata_i[B_TX];
        rx_blk_q <= wdata_i[B_RX];
      end
    end
  end

  always_comb begin
    unique case (addr_i)
      A_MODE:   rdata_o = mode_q;
      A_BLK_EN: rdata_o = {5'b0, rx_blk_q, tx_blk_q, sec_en_i};
      A_BLK_ST: rdata_o = {5'b0, rx_pend_i, tx_pend_i, sec_st_i};
      A_TX_EN:  rdata_o = DW'(tx_en_i);
      A_TX_ST:  rdata_o = DW'(tx_st_i);
      A_RX_EN:  rdata_o = DW'(rx_en_i);
      A_RX_ST:  rdata_o = DW'(rx_st_i);
      default:  rdata_o = '0;
    endcase
  end

  assign mode_o   = mode_q;
  assign tx_blk_o = tx_blk_q;
  assign rx_blk_o = rx_blk_q;

  // R8
  srst_apply_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_o |=> (mode_q == MODE_RST) && !tx_blk_q && !rx_blk_q);
  // R8
  srst_bit_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_q[M_SRST]);
endmodule

// File: rtl/irq_hier_ctrl.sv
module irq_hier_ctrl
  import irqc_pkg::*;
#(
  parameter int unsigned TX_N       = 4,
  parameter int unsigned RX_N       = 4,
  parameter int unsigned SEC_CYCLES = 100_000_000
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            bus_wr_i,
  input  logic            bus_rd_i,
  input  logic [3:0]      bus_addr_i,
  input  logic [7:0]      bus_wdata_i,
  output logic [7:0]      bus_rdata_o,
  input  logic [TX_N-1:0] tx_evt_i,
  input  logic [RX_N-1:0] rx_evt_i,
  output logic [7:0]      mode_o,
  output logic            irq_o
);
  logic srst, tx_blk, rx_blk, tick;
  logic sec_en_we, tx_en_we, rx_en_we, sec_rd, tx_rd, rx_rd;
  logic [0:0] sec_en, sec_st, sec_act;
  logic [TX_N-1:0] tx_en, tx_st, tx_act;
  logic [RX_N-1:0] rx_en, rx_st, rx_act;
  logic auto_dis;

  assign auto_dis = mode_o[M_AUTO];

  irqc_reg_if #(.TX_N(TX_N), .RX_N(RX_N)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_i(bus_wr_i), .rd_i(bus_rd_i), .addr_i(bus_addr_i), .wdata_i(bus_wdata_i),
    .rdata_o(bus_rdata_o), .mode_o(mode_o), .srst_o(srst),
    .tx_blk_o(tx_blk), .rx_blk_o(rx_blk),
    .sec_en_i(sec_en[0]), .sec_st_i(sec_st[0]),
    .tx_pend_i(|tx_act), .rx_pend_i(|rx_act),
    .tx_en_i(tx_en), .tx_st_i(tx_st), .rx_en_i(rx_en), .rx_st_i(rx_st),
    .sec_en_we_o(sec_en_we), .tx_en_we_o(tx_en_we), .rx_en_we_o(rx_en_we),
    .sec_rd_o(sec_rd), .tx_rd_o(tx_rd), .rx_rd_o(rx_rd)
  );

  irqc_sec_timer #(.SEC_CYCLES(SEC_CYCLES)) u_sec_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .srst_i(srst), .tick_o(tick)
  );

  irqc_src_bank #(.N(1)) u_sec_bank (
    .clk_i(clk_i), .rst_ni(rst_ni), .srst_i(srst), .evt_i(tick), .auto_i(auto_dis),
    .en_we_i(sec_en_we), .en_wdata_i(bus_wdata_i[B_SEC]), .st_rd_i(sec_rd),
    .en_o(sec_en), .st_o(sec_st), .act_o(sec_act)
  );

  irqc_src_bank #(.N(TX_N)) u_tx_bank (
    .clk_i(clk_i), .rst_ni(rst_ni), .srst_i(srst), .evt_i(tx_evt_i), .auto_i(auto_dis),
    .en_we_i(tx_en_we), .en_wdata_i(bus_wdata_i[TX_N-1:0]), .st_rd_i(tx_rd),
    .en_o(tx_en), .st_o(tx_st), .act_o(tx_act)
  );

  irqc_src_bank #(.N(RX_N)) u_rx_bank (
    .clk_i(clk_i), .rst_ni(rst_ni), .srst_i(srst), .evt_i(rx_evt_i), .auto_i(auto_dis),
    .en_we_i(rx_en_we), .en_wdata_i(bus_wdata_i[RX_N-1:0]), .st_rd_i(rx_rd),
    .en_o(rx_en), .st_o(rx_st), .act_o(rx_act)
  );

  // block enables only gate; the sec enable is its own block bit
  assign irq_o = sec_act[0] | (tx_blk & (|tx_act)) | (rx_blk & (|rx_act));

  // R4
  blk_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx_blk && !rx_blk && !sec_en[0] && !sec_st[0]) |-> !irq_o);
  // R3
  irq_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (sec_st[0] || (|tx_st) || (|rx_st)));
  // R3
  irq_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(|tx_en) && !(|rx_en) && !sec_en[0] && !auto_dis) |-> !irq_o);
endmodule

// File: tb/irq_hier_ctrl_tb_top.sv
module irq_hier_ctrl_tb_top;
  localparam int unsigned TX_N = 4;
  localparam int unsigned RX_N = 4;
  localparam int unsigned SEC  = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr = 1'b0, rd = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0, rdata, mode;
  logic [TX_N-1:0] tx_evt = '0;
  logic [RX_N-1:0] rx_evt = '0;
  logic irq;
  int total = 0, bad = 0, cyc = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  irq_hier_ctrl #(.TX_N(TX_N), .RX_N(RX_N), .SEC_CYCLES(SEC)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(wr), .bus_rd_i(rd), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .tx_evt_i(tx_evt), .rx_evt_i(rx_evt),
    .mode_o(mode), .irq_o(irq)
  );

  typedef struct packed {
    logic [7:0] mode;
    logic [3:0] en;
    logic [7:0] blk;
    logic [3:0] evt;
    logic       irq;
    logic [3:0] st;
    logic [3:0] en_after;
  } vec_t;

  // mode 0x23: auto off, 0x2B: auto on; blk bit1 = tx block
  localparam vec_t VEC [8] = '{
    '{8'h23, 4'b0001, 8'h02, 4'b0001, 1'b1, 4'b0001, 4'b0001},
    '{8'h23, 4'b0001, 8'h00, 4'b0001, 1'b0, 4'b0001, 4'b0001},
    '{8'h23, 4'b0000, 8'h02, 4'b0001, 1'b0, 4'b0001, 4'b0000},
    '{8'h23, 4'b0110, 8'h02, 4'b0100, 1'b1, 4'b0100, 4'b0110},
    '{8'h2B, 4'b0011, 8'h02, 4'b0010, 1'b1, 4'b0010, 4'b0001},
    '{8'h2B, 4'b0001, 8'h02, 4'b0010, 1'b0, 4'b0010, 4'b0001},
    '{8'h2B, 4'b1111, 8'h00, 4'b1000, 1'b0, 4'b1000, 4'b0111},
    '{8'h23, 4'b1111, 8'h02, 4'b1111, 1'b1, 4'b1111, 4'b1111}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); rd = 1'b1; addr = a; #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic tx_pulse(input logic [3:0] v);
    @(negedge clk); tx_evt = v;
    @(negedge clk); tx_evt = '0; #1;
  endtask

  task automatic wait_irq(output int t);
    t = -1;
    for (int n = 0; n < 4 * SEC; n++) begin
      @(negedge clk); #1;
      if (irq) begin t = cyc; break; end
    end
  endtask

  initial begin
    #(4 * 150000);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int t1, t2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values
    #1 chk("R1 irq", {7'b0, irq}, 8'h00);
    bus_rd(4'h0, d); chk("R1 mode", d, 8'h2B);
    bus_rd(4'h4, d); chk("R1 blk_en", d, 8'h00);
    bus_rd(4'h8, d); chk("R1 tx_en", d, 8'h00);
    bus_rd(4'hA, d); chk("R1 rx_en", d, 8'h00);

    // R2 R3 R4 R5 R7 table walk on the tx section
    for (int k = 0; k < 8; k++) begin
      bus_wr(4'h0, 8'h10);
      bus_wr(4'h0, VEC[k].mode);
      bus_wr(4'h8, {4'h0, VEC[k].en});
      bus_wr(4'h4, VEC[k].blk);
      tx_pulse(VEC[k].evt);
      chk($sformatf("R3/R4 vec%0d irq", k), {7'b0, irq}, {7'b0, VEC[k].irq});
      bus_rd(4'h9, d); chk($sformatf("R2 vec%0d tx_st", k), d, {4'h0, VEC[k].st});
      #1 chk($sformatf("R5 vec%0d irq after read", k), {7'b0, irq}, 8'h00);
      bus_rd(4'h9, d); chk($sformatf("R5 vec%0d cleared", k), d, 8'h00);
      bus_rd(4'h8, d); chk($sformatf("R7 vec%0d tx_en", k), d, {4'h0, VEC[k].en_after});
    end

    // R5 event in same cycle as read wins
    bus_wr(4'h0, 8'h10);
    bus_wr(4'h0, 8'h23);
    tx_pulse(4'b0001);
    @(negedge clk); rd = 1'b1; addr = 4'h9; tx_evt = 4'b0001; #1 d = rdata;
    @(negedge clk); rd = 1'b0; tx_evt = '0;
    chk("R5 read data", d, 8'h01);
    bus_rd(4'h9, d); chk("R5 event wins", d, 8'h01);
    bus_rd(4'h9, d); chk("R5 then cleared", d, 8'h00);

    // R3 R9 rx section and block status pending bit
    bus_wr(4'hA, 8'h01);
    bus_wr(4'h4, 8'h04);
    @(negedge clk); rx_evt = 4'b0001;
    @(negedge clk); rx_evt = '0; #1;
    chk("R3 rx irq", {7'b0, irq}, 8'h01);
    bus_rd(4'h5, d); chk("R9 rx pending", d & 8'h06, 8'h04);
    bus_rd(4'hB, d); chk("R9 rx status", d, 8'h01);
    bus_rd(4'h3, d); chk("R9 unmapped", d, 8'h00);

    // R8 soft reset
    bus_wr(4'h4, 8'h06);
    bus_wr(4'h8, 8'h0F);
    bus_wr(4'h0, 8'h10);
    bus_rd(4'h0, d); chk("R8 mode", d, 8'h2B);
    bus_rd(4'h4, d); chk("R8 blk_en", d, 8'h00);
    bus_rd(4'h8, d); chk("R8 tx_en", d, 8'h00);

    // R6 one-second period, clear on read of 0x05
    bus_wr(4'h0, 8'h23);
    bus_wr(4'h4, 8'h01);
    wait_irq(t1);
    bus_rd(4'h5, d); chk("R6 sec status", d & 8'h01, 8'h01);
    #1 chk("R6 irq cleared", {7'b0, irq}, 8'h00);
    wait_irq(t2);
    chk("R6 period", 8'(t2 - t1), 8'(SEC));
    bus_rd(4'h5, d);

    // R7 auto-disable on one-second source
    bus_wr(4'h0, 8'h2B);
    wait_irq(t1);
    bus_rd(4'h4, d); chk("R7 sec en cleared", d, 8'h00);
    #1 chk("R7 irq held", {7'b0, irq}, 8'h01);
    bus_rd(4'h5, d);
    #1 chk("R7 irq dropped", {7'b0, irq}, 8'h00);
    repeat (SEC + 5) @(negedge clk);
    #1 chk("R7 no further irq", {7'b0, irq}, 8'h00);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule